// File: doc/BRIEF.md
# Test Event Injection Generator

This block sits on one output channel and, when injection is enabled, replaces the received 16-bit data stream with synthetic events, so that the receiver downstream can be exercised without live detector data. With injection disabled, the received words pass straight through to the output.

Each event is launched by a trigger. The trigger is either an accept pulse from the timing system or a single-cycle pulse written by software. Each trigger captures a small record: either the live bunch-crossing ID, event ID and trigger type, or a locally numbered record. The record goes into a short queue. A sequencer then emits, for each queued record, three identification words, N payload words and a closing CRC-16 word. The payload is either an incrementing count or a replay of a pattern memory that is written through a simple address/data port. Because the live timing IDs can be stamped into the header, the downstream receiver's synchronization with the timing system can be checked against the injected data.

Top module: `inj_gen`

## Requirements
- R1: While `inj_en` is 0, `tx_valid`/`tx_data` equal `rx_valid`/`rx_data` in the same cycle, triggers are ignored, any event in progress is abandoned and the pending-trigger queue is emptied; after `inj_en` returns to 1, nothing is emitted until a new trigger arrives.
- R2: An injected event is a gap-free run of `tx_valid`=1 words in this order: word 0 = {4'b0, bcid[11:0]}, word 1 = evid[15:0], word 2 = {8'b0, ttype[7:0]}, then N payload words, then the CRC word.
- R3: With `pat_sel`=0 (count pattern), payload word k (k counted from 0) equals k, zero-extended to 16 bits.
- R4: With `pat_sel`=1 (memory pattern), payload word k equals the pattern-memory entry at address k. An entry is written when `mem_we`=1, at the rising edge, with `mem_wdata` stored at `mem_waddr`. Writes are made while no event is being sent.
- R5: N = `len_m1`+1, which covers 1 to 256. `len_m1` and `pat_sel` are taken when an event starts, and later changes do not affect that event.
- R6: The CRC word is a CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no final inversion. It is computed MSB first over word 0 up to the last payload word.
- R7: A trigger is `tm_accept` or `sw_trig` high at a rising edge while `inj_en`=1. Both high in one cycle count as one trigger. If the sequencer is idle and the queue is empty, word 0 appears after the next rising edge, so one cycle with `tx_valid`=0 follows the trigger edge.
- R8: If `use_tm`=1 in the trigger cycle, the record holds `tm_bcid`, `tm_evid` and `tm_ttype` from that cycle. Otherwise bcid=0, ttype=0, and evid = the number of triggers accepted since reset before this one (modulo 2^16).
- R9: Up to 4 triggers can be pending while an event is sent. When one is pending, the next event's word 0 follows the CRC word in the very next cycle.
- R10: A trigger that arrives while 4 are pending and none leaves the queue in that cycle is dropped. It does not advance the local event number, and it sets `ovf_err`, which stays 1 until reset. A trigger in the cycle where a full queue releases a record is accepted.
- R11: After reset, no event is pending or in progress, `ovf_err`=0 and the local event number is 0. The pattern memory keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inj_en | input | 1 | 1 = injection, 0 = pass received data |
| pat_sel | input | 1 | Payload pattern: 0 count, 1 memory |
| use_tm | input | 1 | Stamp live timing IDs into the record |
| len_m1 | input | 8 | Payload length minus one |
| tm_accept | input | 1 | Trigger accept from the timing system |
| sw_trig | input | 1 | Software trigger pulse |
| tm_bcid | input | 12 | Live bunch-crossing ID |
| tm_evid | input | 16 | Live event ID |
| tm_ttype | input | 8 | Live trigger type |
| mem_we | input | 1 | Pattern memory write strobe |
| mem_waddr | input | 8 | Pattern memory write address |
| mem_wdata | input | 16 | Pattern memory write data |
| rx_valid | input | 1 | Received word valid |
| rx_data | input | 16 | Received word |
| tx_valid | output | 1 | Output word valid |
| tx_data | output | 16 | Output word |
| ovf_err | output | 1 | Sticky trigger-queue overflow flag |

## Verification
Two cases can coincide in one cycle. In the first, a new trigger arrives in the same cycle in which the sequencer pulls the next record from a full queue, on the CRC word of the event being sent. The bench times a trigger to land exactly on that CRC word with four records pending. It expects the trigger to be kept, `ovf_err` to stay 0 and six back-to-back events. In the second, the same pending depth is reached during payload words, where the trigger must be dropped. That case is judged by the sticky flag, by the unchanged local event numbering of the next event, and by the output going quiet after the five queued events.

// File: rtl/inj_pkg.sv
// Shared constants and types for the test event injection generator.
// Assumes 16-bit output words and a 16-bit CRC.
package inj_pkg;
    localparam int WORD_W  = 16;
    localparam int BCID_W  = 12;
    localparam int EVID_W  = 16;
    localparam int TTYPE_W = 8;

    localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] CRC_INIT = 16'hFFFF;

    // Record captured at each trigger
    typedef struct packed {
        logic [BCID_W-1:0]  bcid;
        logic [EVID_W-1:0]  evid;
        logic [TTYPE_W-1:0] ttype;
    } trig_rec_t;

    // Word currently presented by the sequencer
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_EVID,
        S_TYPE,
        S_PAY,
        S_CRC
    } seq_state_t;
endpackage

// File: rtl/inj_trig_fifo.sv
// Pending-trigger queue. Holds DEPTH records, accepts a push when not full
// or when a pop happens in the same cycle, and is emptied by flush.
// Assumes pop is only requested while not flushing.
module inj_trig_fifo
    import inj_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  trig_rec_t din,
    input  logic      pop,
    output trig_rec_t dout,
    output logic      empty,
    output logic      full,
    output logic      accepted
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    trig_rec_t       slots [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign do_pop   = pop && !empty;
    assign accepted = push && (!full || do_pop);
    assign dout     = slots[rp];

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accepted) wp <= ptr_next(wp);
            if (do_pop)   rp <= ptr_next(rp);
            case ({accepted, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Record storage, no reset needed
    always_ff @(posedge clk) begin
        if (accepted) slots[wp] <= din;
    end

    a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r10_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/inj_pattern_mem.sv
// Pattern memory: one synchronous write port, one combinational read port.
// Assumes no write to the address being read while an event is sent.
module inj_pattern_mem
    import inj_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] cells [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/inj_crc16.sv
// Word-wide CRC-16 accumulator (poly 0x1021, MSB first, no final xor).
// init loads the start value; en folds din into the running value.
module inj_crc16
    import inj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] crc
);
    function automatic logic [WORD_W-1:0] fold(input logic [WORD_W-1:0] c,
                                                input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] x;
        x = c ^ d;
        for (int i = 0; i < WORD_W; i++) begin
            x = {x[WORD_W-2:0], 1'b0} ^ (x[WORD_W-1] ? CRC_POLY : '0);
        end
        return x;
    endfunction

    // Running CRC register
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= CRC_INIT;
        else if (en)        crc <= fold(crc, din);
    end
endmodule

// File: rtl/inj_gen.sv
// Test event injection generator for one output channel. Queues trigger
// records, then emits per record: bcid word, evid word, ttype word,
// N payload words (count or memory pattern) and a CRC-16 word.
// With inj_en low the received stream passes through unchanged.
module inj_gen
    import inj_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inj_en,
    input  logic               pat_sel,
    input  logic               use_tm,
    input  logic [MEM_AW-1:0]  len_m1,
    input  logic               tm_accept,
    input  logic               sw_trig,
    input  logic [BCID_W-1:0]  tm_bcid,
    input  logic [EVID_W-1:0]  tm_evid,
    input  logic [TTYPE_W-1:0] tm_ttype,
    input  logic               mem_we,
    input  logic [MEM_AW-1:0]  mem_waddr,
    input  logic [WORD_W-1:0]  mem_wdata,
    input  logic               rx_valid,
    input  logic [WORD_W-1:0]  rx_data,
    output logic               tx_valid,
    output logic [WORD_W-1:0]  tx_data,
    output logic               ovf_err
);
    seq_state_t         state;
    trig_rec_t          rec_in, cur;
    logic [EVID_W-1:0]  local_evid;
    logic [MEM_AW-1:0]  idx, cur_len;
    logic               cur_mem;
    logic               trig, q_empty, q_full, q_acc, start;
    logic [WORD_W-1:0]  mem_rd, crc, word;

    assign trig  = inj_en && (tm_accept || sw_trig);
    assign start = inj_en && !q_empty && (state == S_IDLE || state == S_CRC);

    // Record contents for the trigger of this cycle
    always_comb begin
        if (use_tm) begin
            rec_in = '{bcid: tm_bcid, evid: tm_evid, ttype: tm_ttype};
        end else begin
            rec_in = '{bcid: '0, evid: local_evid, ttype: '0};
        end
    end

    inj_trig_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!inj_en),
        .push     (trig),
        .din      (rec_in),
        .pop      (start),
        .dout     (cur_next_rec),
        .empty    (q_empty),
        .full     (q_full),
        .accepted (q_acc)
    );

    trig_rec_t cur_next_rec;

    inj_pattern_mem #(.AW(MEM_AW)) u_pmem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (idx),
        .rdata (mem_rd)
    );

    inj_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .en    (state == S_HDR || state == S_EVID || state == S_TYPE || state == S_PAY),
        .din   (word),
        .crc   (crc)
    );

    // Local event number and sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_evid <= '0;
            ovf_err    <= 1'b0;
        end else begin
            if (q_acc)          local_evid <= local_evid + 1'b1;
            if (trig && !q_acc) ovf_err    <= 1'b1;
        end
    end

    // Event sequencer: steps through the words of one event
    always_ff @(posedge clk) begin
        if (!rst_n || !inj_en) begin
            state <= S_IDLE;
            idx   <= '0;
        end else if (start) begin
            state   <= S_HDR;
            idx     <= '0;
            cur     <= cur_next_rec;
            cur_len <= len_m1;
            cur_mem <= pat_sel;
        end else begin
            case (state)
                S_HDR:  state <= S_EVID;
                S_EVID: state <= S_TYPE;
                S_TYPE: state <= S_PAY;
                S_PAY: begin
                    if (idx == cur_len) state <= S_CRC;
                    else                idx   <= idx + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Word presented in the current sequencer state
    always_comb begin
        case (state)
            S_HDR:   word = WORD_W'(cur.bcid);
            S_EVID:  word = WORD_W'(cur.evid);
            S_TYPE:  word = WORD_W'(cur.ttype);
            S_PAY:   word = cur_mem ? mem_rd : WORD_W'(idx);
            S_CRC:   word = crc;
            default: word = '0;
        endcase
    end

    // Output select between injection and pass-through
    always_comb begin
        if (inj_en) begin
            tx_valid = (state != S_IDLE);
            tx_data  = word;
        end else begin
            tx_valid = rx_valid;
            tx_data  = rx_data;
        end
    end

    a_r1_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en |=> (state == S_IDLE));
    a_r5_crc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && state == S_PAY && idx == cur_len) |=> (state == S_CRC));
    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && state == S_IDLE && !q_empty) |=> (state == S_HDR));
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && state == S_CRC && !q_empty) |=> (state == S_HDR));
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

// File: tb/inj_gen_test.sv
`timescale 1ns/1ps
module inj_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inj_en = 1'b0, pat_sel = 1'b0, use_tm = 1'b0;
    logic [7:0]  len_m1 = 8'd0;
    logic        tm_accept = 1'b0, sw_trig = 1'b0;
    logic [11:0] tm_bcid = '0;
    logic [15:0] tm_evid = '0;
    logic [7:0]  tm_ttype = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_waddr = '0;
    logic [15:0] mem_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        ovf_err;

    int vectors = 0, miscompares = 0, int_cnt = 0;
    bit finished = 0;
    logic [15:0] bmem [256];

    always #2.5 clk = ~clk;

    inj_gen uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic fb;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c = c << 1;
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        int_cnt = 0;
    endtask

    task automatic pulse(input bit ext, input bit sw);
        @(negedge clk); tm_accept = ext; sw_trig = sw;
        @(negedge clk); tm_accept = 1'b0; sw_trig = 1'b0;
    endtask

    // Check one full event starting at the first valid sample
    task automatic check_event(input logic [11:0] b, input logic [15:0] e, input logic [7:0] ty,
                               input int n, input bit memmode, input int maxwait);
        int w = 0;
        logic [15:0] c = 16'hFFFF, exp;
        while (!tx_valid) begin
            if (w == maxwait) begin
                check(0, "R9 event start", 0, 1);
                return;
            end
            @(negedge clk); w++;
        end
        for (int k = 0; k < n + 4; k++) begin
            if (k == 0)          exp = {4'b0, b};
            else if (k == 1)     exp = e;
            else if (k == 2)     exp = {8'b0, ty};
            else if (k < n + 3)  exp = memmode ? bmem[k-3] : 16'(k - 3);
            else                 exp = c;
            if (k < n + 3) c = ref_crc(c, exp);
            check(tx_valid == 1'b1, "R2 valid run", int'(tx_valid), 1);
            if (k < 3)           check(tx_data == exp, "R2/R8 id word", tx_data, exp);
            else if (k < n + 3)  check(tx_data == exp, memmode ? "R4 payload" : "R3 payload", tx_data, exp);
            else                 check(tx_data == exp, "R6 crc", tx_data, exp);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [11:0] b; logic [15:0] e; logic [7:0] ty;
        int n, src; bit mm, ut;
        void'($urandom(32'h5EED1234));
        do_reset();
        @(negedge clk);
        // R11: reset state
        inj_en = 1'b1;
        #1;
        check(tx_valid == 1'b0, "R11 idle after reset", tx_valid, 0);
        check(ovf_err == 1'b0, "R11 ovf clear", ovf_err, 0);
        // preload pattern memory
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            bmem[a] = 16'($urandom); mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = bmem[a];
        end
        @(negedge clk); mem_we = 1'b0;

        // R1: pass-through and ignored triggers
        inj_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'($urandom); rx_data = 16'($urandom); tm_accept = 1'b1; #1;
            check(tx_valid == rx_valid && tx_data == rx_data, "R1 pass-through", tx_data, rx_data);
        end
        @(negedge clk); tm_accept = 1'b0; inj_en = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R1 ignored trigger", tx_valid, 0);
        end

        // R7: trigger latency, software trigger, local stamp
        use_tm = 1'b0; pat_sel = 1'b0; len_m1 = 8'd2;
        pulse(0, 1);
        check(tx_valid == 1'b0, "R7 gap cycle", tx_valid, 0);
        @(negedge clk);
        check(tx_valid == 1'b1 && tx_data == 16'h0000, "R7 header timing", tx_data, 0);
        check_event(0, 16'(int_cnt), 0, 3, 0, 0);
        int_cnt++;

        // Random events, one at a time
        for (int it = 0; it < 40; it++) begin
            mm = 1'($urandom); ut = 1'($urandom);
            n = ($urandom % 8 == 0) ? 256 : 1 + $urandom % 12;
            src = 1 + $urandom % 3;
            b = 12'($urandom); e = 16'($urandom); ty = 8'($urandom);
            pat_sel = mm; use_tm = ut; len_m1 = 8'(n - 1);
            tm_bcid = b; tm_evid = e; tm_ttype = ty;
            pulse(src[0], src[1]);
            if (ut) check_event(b, e, ty, n, mm, 3);
            else    check_event(0, 16'(int_cnt), 0, n, mm, 3);
            int_cnt++;
            repeat ($urandom % 4) @(negedge clk);
        end

        // R5: length and pattern taken at event start
        use_tm = 1'b1; tm_bcid = 12'hABC; tm_evid = 16'h1357; tm_ttype = 8'h5A;
        pat_sel = 1'b1; len_m1 = 8'd4;
        pulse(1, 1);
        @(negedge clk);
        pat_sel = 1'b0; len_m1 = 8'd30;
        check_event(12'hABC, 16'h1357, 8'h5A, 5, 1, 2);
        int_cnt++;
        check(tx_valid == 1'b0, "R5 length held", tx_valid, 0);

        // R1: abort mid-event flushes the queue
        pat_sel = 1'b0; len_m1 = 8'd19;
        pulse(1, 0); pulse(1, 0); pulse(0, 1);
        repeat (3) @(negedge clk);
        inj_en = 1'b0;
        repeat (3) begin
            @(negedge clk); rx_valid = 1'($urandom); rx_data = 16'($urandom); sw_trig = 1'b1; #1;
            check(tx_valid == rx_valid && tx_data == rx_data, "R1 abort pass-through", tx_data, rx_data);
        end
        @(negedge clk); sw_trig = 1'b0; inj_en = 1'b1;
        repeat (8) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R1 queue flushed", tx_valid, 0);
        end

        // R10: overflow drops the trigger during payload
        do_reset();
        use_tm = 1'b0; pat_sel = 1'b0; len_m1 = 8'd9;
        fork
            begin
                for (int k = 0; k < 6; k++) pulse(1, 0);
            end
            begin
                for (int k = 0; k < 5; k++) check_event(0, 16'(k), 0, 10, 0, k == 0 ? 5 : 0);
            end
        join
        check(ovf_err == 1'b1, "R10 overflow flagged", ovf_err, 1);
        check(tx_valid == 1'b0, "R10 dropped trigger absent", tx_valid, 0);
        pulse(0, 1);
        check_event(0, 16'd5, 0, 10, 0, 3);
        check(ovf_err == 1'b1, "R10 flag sticky", ovf_err, 1);

        // R9/R10: trigger on the CRC word of a full queue is kept
        do_reset();
        check(ovf_err == 1'b0, "R11 flag cleared", ovf_err, 0);
        fork
            begin
                for (int k = 0; k < 5; k++) pulse(1, 0);
                repeat (5) @(negedge clk);
                pulse(0, 1);
            end
            begin
                for (int k = 0; k < 6; k++) check_event(0, 16'(k), 0, 10, 0, k == 0 ? 5 : 0);
            end
        join
        check(ovf_err == 1'b0, "R10 same-cycle push kept", ovf_err, 0);
        check(tx_valid == 1'b0, "R9 queue drained", tx_valid, 0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule